// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block follows the power state of a core that carries several logical processors. Each logical processor has its own halt and stop-grant request, plus its own interrupt request line. One level-sensitive sleep pin, one bus snoop request and a clear strobe for the violation flag are shared. From these inputs the block derives a core-wide state: Normal, AutoHALT, Stop-Grant or Sleep. From that state it decides whether a snoop or an interrupt is accepted in the current cycle and whether the core clock may run.

Sleep is a deeper state reached through Stop-Grant. The sequencer enters Sleep only when the sleep pin rises while every logical processor already sits in Stop-Grant. If the pin rises at any other time, the block treats it as a protocol error. It raises a sticky violation flag and stays out of Sleep. The surrounding logic reads the accept outputs to gate snoop and interrupt servicing, and reads the clock enable to drive its own clock gating.

Top module: `lps_seq`

## Requirements
- R1: After reset, `pwr_state` is 0 (Normal), `core_clk_en` is 1, `viol_flag` is 0, and every logical processor is running.
- R2: `pwr_state` encodes the core state as follows. 0 means at least one logical processor is running. 1 (AutoHALT) means none is running and at least one is halted. 2 (Stop-Grant) means all are stopped. 3 means Sleep. A running processor with `halt_req` high becomes halted at the next clock edge.
- R3: When a processor is halted and its `intr_req` bit is high, it returns to running at the next edge. In every state except Sleep, `intr_ack` equals `intr_req` in the same cycle.
- R4: In states 0, 1 and 2, `snoop_ack` follows `snoop_req` in the same cycle.
- R5: A low-to-high transition of `sleep_pin`, sampled while every processor is stopped, puts the block in state 3 at that edge.
- R6: In Sleep, `snoop_ack` and `intr_ack` stay 0, and every processor stays stopped even if its `stop_req` drops.
- R7: When `sleep_pin` is low while the block is in Sleep, the block returns to state 2 at the next edge.
- R8: A low-to-high transition of `sleep_pin` while any processor is not stopped sets `viol_flag` at that edge. The block does not enter Sleep, even if all processors stop later while the pin stays high.
- R9: `viol_flag` stays set until reset or until a cycle with `viol_clr` high. If a new violation and `viol_clr` occur in the same cycle, the flag is set.
- R10: A stopped processor returns to running at the first edge where its `stop_req` is low, `sleep_pin` is low and the block was not in Sleep.
- R11: `core_clk_en` is 1 in states 0 and 1, and 0 in states 2 and 3.
- R12: `stop_req` overrides `halt_req`. A processor that is running or halted with `stop_req` high becomes stopped at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_req | input | NUM_LP | Per-processor halt request |
| stop_req | input | NUM_LP | Per-processor stop-grant request (level) |
| intr_req | input | NUM_LP | Per-processor interrupt request |
| sleep_pin | input | 1 | Sleep request pin (level) |
| snoop_req | input | 1 | Bus snoop request |
| viol_clr | input | 1 | Clears the violation flag |
| pwr_state | output | 2 | Core power state, encoded per R2 |
| snoop_ack | output | 1 | Snoop accepted this cycle |
| intr_ack | output | NUM_LP | Interrupt accepted this cycle, per processor |
| core_clk_en | output | 1 | Core clock enable |
| viol_flag | output | 1 | Sticky sleep protocol violation |

## Verification
The bench raises the sleep pin while only one of two processors is stopped. A design that checks a single processor would enter Sleep in that case instead of flagging the error. It then keeps the pin high while both processors stop. A level-triggered design would slip into Sleep late, which is wrong. It drops the stop requests while the block sleeps, then releases the pin. A design that does not hold the processors stopped would wake a processor inside Sleep or skip the Stop-Grant step on the way out. It also fires a clear and a fresh violation in the same cycle and asserts halt together with stop. A design with the priorities reversed would lose the flag or report AutoHALT.

// File: rtl/lps_pkg.sv
package lps_pkg;
    typedef enum logic [1:0] {
        LP_RUN  = 2'd0,
        LP_HALT = 2'd1,
        LP_STOP = 2'd2
    } lp_state_e;

    typedef enum logic [1:0] {
        PS_NORMAL   = 2'd0,
        PS_AUTOHALT = 2'd1,
        PS_STOPGNT  = 2'd2,
        PS_SLEEP    = 2'd3
    } pwr_state_e;
endpackage

// File: rtl/lps_lp_fsm.sv
module lps_lp_fsm
    import lps_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt_req,
    input  logic      stop_req,
    input  logic      intr_req,
    input  logic      sleep_pin,
    input  logic      asleep,
    output lp_state_e state_o
);
    typedef struct packed {
        lp_state_e st;
    } lp_regs_t;

    lp_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            LP_RUN: begin
                if (stop_req)      s_d.st = LP_STOP;
                else if (halt_req) s_d.st = LP_HALT;
            end
            LP_HALT: begin
                if (stop_req)      s_d.st = LP_STOP;
                else if (intr_req) s_d.st = LP_RUN;
            end
            LP_STOP: begin
                if (!stop_req && !sleep_pin && !asleep) s_d.st = LP_RUN;
            end
            default: s_d.st = LP_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.st <= LP_RUN;
        else        s_q    <= s_d;
    end

    assign state_o = s_q.st;

    // R6: a sleeping core keeps every processor stopped
    a_r6_held_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> (state_o == LP_STOP));

    // R12: stop request always lands in stopped state
    a_r12_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (state_o == LP_STOP));
endmodule

// File: rtl/lps_sleep_ctl.sv
module lps_sleep_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic all_stop,
    input  logic sleep_pin,
    input  logic viol_clr,
    output logic asleep,
    output logic viol
);
    typedef struct packed {
        logic asleep;
        logic pin_prev;
        logic viol;
    } sc_regs_t;

    sc_regs_t s_d, s_q;
    logic     pin_rise;

    always_comb begin
        s_d          = s_q;
        pin_rise     = sleep_pin && !s_q.pin_prev;
        s_d.pin_prev = sleep_pin;
        if (s_q.asleep) begin
            if (!sleep_pin) s_d.asleep = 1'b0;
        end else if (pin_rise && all_stop) begin
            s_d.asleep = 1'b1;
        end
        if (viol_clr) s_d.viol = 1'b0;
        if (pin_rise && !all_stop && !s_q.asleep) s_d.viol = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.asleep   <= 1'b0;
            s_q.pin_prev <= 1'b1;
            s_q.viol     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign asleep = s_q.asleep;
    assign viol   = s_q.viol;

    // R5: sleep is only entered from a fully stopped core
    a_r5_entry_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(all_stop));

    // R7: dropping the pin ends sleep at the next edge
    a_r7_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !sleep_pin) |=> !asleep);

    // R9: flag holds without a clear
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && !viol_clr) |=> viol);
endmodule

// File: rtl/lps_seq.sv
module lps_seq
    import lps_pkg::*;
#(
    parameter int NUM_LP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_LP-1:0] halt_req,
    input  logic [NUM_LP-1:0] stop_req,
    input  logic [NUM_LP-1:0] intr_req,
    input  logic              sleep_pin,
    input  logic              snoop_req,
    input  logic              viol_clr,
    output logic [1:0]        pwr_state,
    output logic              snoop_ack,
    output logic [NUM_LP-1:0] intr_ack,
    output logic              core_clk_en,
    output logic              viol_flag
);
    lp_state_e  lp_st [NUM_LP];
    logic       asleep;
    logic       all_stop;
    logic       any_run;
    pwr_state_e ps;

    for (genvar g = 0; g < NUM_LP; g++) begin : g_lp
        lps_lp_fsm u_lp (
            .clk      (clk),
            .rst_n    (rst_n),
            .halt_req (halt_req[g]),
            .stop_req (stop_req[g]),
            .intr_req (intr_req[g]),
            .sleep_pin(sleep_pin),
            .asleep   (asleep),
            .state_o  (lp_st[g])
        );
    end

    always_comb begin
        all_stop = 1'b1;
        any_run  = 1'b0;
        for (int i = 0; i < NUM_LP; i++) begin
            if (lp_st[i] != LP_STOP) all_stop = 1'b0;
            if (lp_st[i] == LP_RUN)  any_run  = 1'b1;
        end
    end

    lps_sleep_ctl u_sleep (
        .clk      (clk),
        .rst_n    (rst_n),
        .all_stop (all_stop),
        .sleep_pin(sleep_pin),
        .viol_clr (viol_clr),
        .asleep   (asleep),
        .viol     (viol_flag)
    );

    always_comb begin
        if (asleep)        ps = PS_SLEEP;
        else if (any_run)  ps = PS_NORMAL;
        else if (all_stop) ps = PS_STOPGNT;
        else               ps = PS_AUTOHALT;
    end

    assign pwr_state   = ps;
    assign snoop_ack   = snoop_req && !asleep;
    assign intr_ack    = asleep ? '0 : intr_req;
    assign core_clk_en = (ps == PS_NORMAL) || (ps == PS_AUTOHALT);

    // R6: nothing is accepted while asleep
    a_r6_quiet_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd3) |-> (!snoop_ack && (intr_ack == '0)));

    // R11: clock is off whenever the sleep controller reports sleep
    a_r11_clk_off_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !core_clk_en);

    // R4: snoops outside sleep are always taken
    a_r4_snoop_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_req && pwr_state != 2'd3) |-> snoop_ack);
endmodule

// File: tb/lps_seq_tb.sv
`timescale 1ns/1ps
module lps_seq_tb;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] halt_req, stop_req, intr_req, intr_ack;
    logic         sleep_pin, snoop_req, viol_clr;
    logic [1:0]   pwr_state;
    logic         snoop_ack, core_clk_en, viol_flag;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lps_seq #(.NUM_LP(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
        .intr_req(intr_req), .sleep_pin(sleep_pin), .snoop_req(snoop_req),
        .viol_clr(viol_clr), .pwr_state(pwr_state), .snoop_ack(snoop_ack),
        .intr_ack(intr_ack), .core_clk_en(core_clk_en), .viol_flag(viol_flag)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0; halt_req = '0; stop_req = '0; intr_req = '0;
        sleep_pin = 1'b0; snoop_req = 1'b0; viol_clr = 1'b0;
        tick; tick;
        rst_n = 1'b1;
        tick;
    endtask

    task automatic t_reset;
        do_reset;
        chk("R1 state", pwr_state, 0);
        chk("R1 clk_en", core_clk_en, 1);
        chk("R1 viol", viol_flag, 0);
        chk("R1 snoop_ack", snoop_ack, 0);
    endtask

    task automatic t_halt_intr;
        do_reset;
        halt_req = 2'b11; tick; halt_req = '0;
        chk("R2 autohalt", pwr_state, 1);
        chk("R11 clk_en autohalt", core_clk_en, 1);
        snoop_req = 1'b1; #0.5;
        chk("R4 snoop autohalt", snoop_ack, 1);
        snoop_req = 1'b0;
        intr_req = 2'b01; #0.5;
        chk("R3 intr_ack", intr_ack, 1);
        tick; intr_req = '0;
        chk("R3 wake", pwr_state, 0);
        stop_req = 2'b10; tick;
        halt_req = 2'b01; tick; halt_req = '0;
        chk("R2 halt+stop mix", pwr_state, 1);
        stop_req = 2'b11; tick;
        chk("R12 halted to stop", pwr_state, 2);
    endtask

    task automatic t_stop_sleep;
        do_reset;
        halt_req = 2'b11; stop_req = 2'b11; tick; halt_req = '0;
        chk("R12 stop over halt", pwr_state, 2);
        chk("R11 clk_en stopgrant", core_clk_en, 0);
        snoop_req = 1'b1; #0.5;
        chk("R4 snoop stopgrant", snoop_ack, 1);
        sleep_pin = 1'b1; tick;
        chk("R5 sleep entry", pwr_state, 3);
        chk("R5 no viol", viol_flag, 0);
        intr_req = 2'b11; #0.5;
        chk("R6 snoop blocked", snoop_ack, 0);
        chk("R6 intr blocked", intr_ack, 0);
        chk("R11 clk_en sleep", core_clk_en, 0);
        intr_req = '0; snoop_req = 1'b0;
        stop_req = '0; tick;
        chk("R6 stays asleep", pwr_state, 3);
        sleep_pin = 1'b0; tick;
        chk("R7 back to stopgrant", pwr_state, 2);
        tick;
        chk("R10 resume normal", pwr_state, 0);
    endtask

    task automatic t_violation;
        do_reset;
        stop_req = 2'b01; tick;
        chk("R2 partial stop normal", pwr_state, 0);
        sleep_pin = 1'b1; tick;
        chk("R8 viol partial", viol_flag, 1);
        chk("R8 no sleep", pwr_state, 0);
        stop_req = 2'b11; tick; tick;
        chk("R8 no late sleep", pwr_state, 2);
        stop_req = '0; tick;
        chk("R10 held by pin", pwr_state, 2);
        sleep_pin = 1'b0; tick;
        chk("R10 resume", pwr_state, 0);
        chk("R9 sticky", viol_flag, 1);
        viol_clr = 1'b1; tick; viol_clr = 1'b0;
        chk("R9 cleared", viol_flag, 0);
        sleep_pin = 1'b1; viol_clr = 1'b1; tick; viol_clr = 1'b0;
        chk("R9 set wins", viol_flag, 1);
        sleep_pin = 1'b0; viol_clr = 1'b1; tick; viol_clr = 1'b0;
        chk("R9 clear again", viol_flag, 0);
    endtask

    initial begin
        fork
            begin
                t_reset;
                t_halt_intr;
                t_stop_sleep;
                t_violation;
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=1 expected=0");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule